// File: doc/BRIEF.md
# Programmable Card Clock Divider

This block produces the clock sent to a smart card from a faster input clock. A two-bit select picks one of four ratios: the input passed straight through, or the input divided by 2, 4 or 8. For the divided ratios the card clock comes directly from one flip-flop that toggles every half period, so high and low phases are always exactly equal, however many input cycles that takes. With the pass-through ratio the output is the input clock gated, so its duty cycle is that of the input.

An activation sequencer drives a single enable. While the enable is low the card clock sits at logic low. Raising it starts the clock and lowering it stops the clock. Both happen only at a point where the output is already low, so the card never sees a shortened high pulse. The ratio is captured when the clock starts and held until the clock has stopped. The half-period counter restarts from zero on each start, so the first rising edge always lands a fixed number of input cycles after the enable is seen.

Top module: `card_clk_div`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released with the enable low, `cclk_o` is low.
- R2: The ratio code on `sel_i` is: 2'b00 divide by 8, 2'b01 divide by 4, 2'b11 divide by 2, 2'b10 pass the input clock through.
- R3: In a divided mode every high phase and every low phase of `cclk_o` lasts exactly N/2 input clock cycles, where N is the selected ratio.
- R4: In pass-through mode `cclk_o` is high during the high phase and low during the low phase of each enabled input cycle. The first gated pulse is the input cycle after the rising edge that sees the enable. The last gated pulse is the cycle that begins at the edge that first sees the enable low.
- R5: While the block is stopped, `cclk_o` stays low whatever `sel_i` does.
- R6: In a divided mode, if the input rising edge that first sees `en_i` high is edge 0, then `cclk_o` first goes high at edge N/2.
- R7: When `en_i` drops while `cclk_o` is high, the high phase runs to its full N/2 length and the output then stays low. When `en_i` drops while `cclk_o` is low, the output stays low from then on.
- R8: A change of `sel_i` while the clock is running has no effect on the running clock.
- R9: The ratio used by a new start is the value of `sel_i` at the edge that first sees `en_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Ratio select code (see R2) |
| en_i | input | 1 | Clock enable from the activation sequencer |
| cclk_o | output | 1 | Card clock |

## Verification
A half-period counter that wraps at the wrong count shows up on the next phase of `cclk_o` as a high or low phase of the wrong length. That can be as soon as N/2 cycles after a start. A missed counter clear or a wrong captured ratio moves the first rising edge away from edge N/2. A stop decision taken in the wrong phase shows up within one half period, either as a cut-short high pulse or as an extra pulse after the enable has dropped. The bench compares `cclk_o` in both halves of every input cycle against a waveform it derives from the ratio and the enable timing. This makes an error visible in the very cycle it first appears.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // Ratio select codes; the order is not monotonic in the ratio
    typedef enum logic [1:0] {
        SEL_DIV8   = 2'b00,
        SEL_DIV4   = 2'b01,
        SEL_BYPASS = 2'b10,
        SEL_DIV2   = 2'b11
    } ratio_sel_e;

endpackage

// File: rtl/ccd_ratio_dec.sv
module ccd_ratio_dec
    import ccd_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [1:0]       sel_i,
    output logic             bypass_o,
    output logic [CNT_W-1:0] half_m1_o
);

    // Half period minus one, in input cycles
    always_comb begin
        bypass_o  = 1'b0;
        half_m1_o = '0;
        case (sel_i)
            SEL_DIV8:   half_m1_o = CNT_W'(3);
            SEL_DIV4:   half_m1_o = CNT_W'(1);
            SEL_DIV2:   half_m1_o = CNT_W'(0);
            SEL_BYPASS: bypass_o  = 1'b1;
            default:    half_m1_o = '0;
        endcase
    end

endmodule

// File: rtl/ccd_core.sv
module ccd_core #(
    parameter int CNT_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             dec_bypass_i,
    input  logic [CNT_W-1:0] dec_half_m1_i,
    output logic             run_o,
    output logic             bypass_o,
    output logic             div_o,
    output logic [CNT_W-1:0] half_m1_o
);

    typedef struct packed {
        logic             run;
        logic             bypass;
        logic [CNT_W-1:0] half_m1;
        logic [CNT_W-1:0] cnt;
        logic             div;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            // stopped: counter cleared, ratio captured on start
            st_d.cnt = '0;
            st_d.div = 1'b0;
            if (en_i) begin
                st_d.run     = 1'b1;
                st_d.bypass  = dec_bypass_i;
                st_d.half_m1 = dec_half_m1_i;
            end
        end else if (st_q.bypass) begin
            if (!en_i) begin
                st_d.run = 1'b0;
            end
        end else begin
            if (!en_i && !st_q.div) begin
                // stop only from the low phase
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else if (st_q.cnt == st_q.half_m1) begin
                st_d.cnt = '0;
                st_d.div = ~st_q.div;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o     = st_q.run;
    assign bypass_o  = st_q.bypass;
    assign div_o     = st_q.div;
    assign half_m1_o = st_q.half_m1;

endmodule

// File: rtl/ccd_gate.sv
module ccd_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic gate_o
);

    logic gate_d, gate_q;

    // updated on the falling edge so the gated clock never cuts a high phase
    always_comb begin
        gate_d = arm_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q;

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
    parameter int CNT_W = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       en_i,
    output logic       cclk_o
);

    logic             dec_bypass;
    logic [CNT_W-1:0] dec_half_m1;
    logic             run_q;
    logic             bypass_q;
    logic             div_q;
    logic             gate_q;
    logic [CNT_W-1:0] half_m1_q;

    ccd_ratio_dec #(.CNT_W(CNT_W)) u_dec (
        .sel_i     (sel_i),
        .bypass_o  (dec_bypass),
        .half_m1_o (dec_half_m1)
    );

    ccd_core #(.CNT_W(CNT_W)) u_core (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en_i),
        .dec_bypass_i  (dec_bypass),
        .dec_half_m1_i (dec_half_m1),
        .run_o         (run_q),
        .bypass_o      (bypass_q),
        .div_o         (div_q),
        .half_m1_o     (half_m1_q)
    );

    ccd_gate u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (run_q & bypass_q),
        .gate_o (gate_q)
    );

    assign cclk_o = bypass_q ? (clk_i & gate_q) : div_q;

endmodule

// File: rtl/ccd_chk.sv
module ccd_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       sel_i,
    input logic             en_i,
    input logic             run_q,
    input logic             bypass_q,
    input logic             div_q,
    input logic             gate_q,
    input logic [CNT_W-1:0] half_m1_q
);

    logic [CNT_W:0] hi_len, lo_len;
    logic [CNT_W:0] half_len;

    assign half_len = {1'b0, half_m1_q} + (CNT_W+1)'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= div_q ? hi_len + (CNT_W+1)'(1) : '0;
            lo_len <= (run_q && !div_q) ? lo_len + (CNT_W+1)'(1) : '0;
        end
    end

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(div_q) |-> (hi_len == half_len)); // R3

    AST_LOW_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_q) |-> (lo_len == half_len)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> (!div_q && !gate_q)); // R5

    AST_STOP_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !div_q) |=> !div_q); // R7

    AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $past(run_q)) |-> ($stable(half_m1_q) && $stable(bypass_q))); // R8

    AST_RATIO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_q) |-> (bypass_q == ($past(sel_i) == 2'b10))); // R9

endmodule

bind card_clk_div ccd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .en_i      (en_i),
    .run_q     (run_q),
    .bypass_q  (bypass_q),
    .div_q     (div_q),
    .gate_q    (gate_q),
    .half_m1_q (half_m1_q)
);

// File: tb/card_clk_div_tb_top.sv
module card_clk_div_tb_top;

    logic       clk_i  = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en_i   = 1'b0;
    logic [1:0] sel_i  = 2'b00;
    logic       cclk_o;

    typedef struct {
        logic  hi;
        logic  lo;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk_i = ~clk_i;

    card_clk_div dut_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel_i),
        .en_i   (en_i),
        .cclk_o (cclk_o)
    );

    task automatic check(input logic act, input logic exp, input string req, input string ph);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s phase) at %0t: actual %0b expected %0b", req, ph, $time, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: one item per input cycle, expected level derived from R2..R9
    task automatic session(input logic [1:0] sel0, input logic [1:0] sel_late, input int swap_at,
                           input int on_len, input int off_len, input string req);
        int   half;
        bit   byp;
        logic prev;
        logic lvl;
        logic raw;
        byp  = 1'b0;
        half = 1;
        case (sel0)
            2'b00: half = 4;
            2'b01: half = 2;
            2'b11: half = 1;
            default: byp = 1'b1;
        endcase
        prev = 1'b0;
        for (int k = 0; k < on_len + off_len; k++) begin
            @(negedge clk_i);
            en_i  = (k < on_len);
            sel_i = (k >= swap_at) ? sel_late : sel0;
            if (byp) begin
                exp_q.push_back('{(k >= 1 && k <= on_len), 1'b0, req});
            end else begin
                raw  = ((k / half) % 2) == 1;
                lvl  = (k < on_len) ? raw : (prev && raw);
                prev = lvl;
                exp_q.push_back('{lvl, lvl, req});
            end
        end
    endtask

    // Monitor: pops one item per rising edge, samples both clock phases
    initial begin
        exp_t e;
        forever begin
            @(posedge clk_i);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(cclk_o, e.hi, e.req, "high");
                #5;
                check(cclk_o, e.lo, e.req, "low");
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        // R1: reset holds output low even with enable and pass-through selected
        en_i  = 1'b1;
        sel_i = 2'b10;
        repeat (3) @(posedge clk_i);
        #2 check(cclk_o, 1'b0, "R1", "high");
        @(negedge clk_i);
        en_i   = 1'b0;
        rst_ni = 1'b1;
        repeat (2) @(posedge clk_i);
        #2 check(cclk_o, 1'b0, "R1", "high");

        // R2/R3/R6: divide by 8, stop while low (R7)
        session(2'b00, 2'b00, 999, 20, 20, "R3");
        // R6/R7: divide by 4, enable drops in a high phase
        session(2'b01, 2'b01, 999, 11, 12, "R7");
        // R2/R3: divide by 2
        session(2'b11, 2'b11, 999, 9, 10, "R2");
        // R4: pass-through
        session(2'b10, 2'b10, 999, 6, 8, "R4");
        // R8: select moves to 11 mid-run, divide by 8 must continue
        session(2'b00, 2'b11, 8, 20, 12, "R8");
        // R5: idle with select toggling
        session(2'b01, 2'b10, 3, 0, 10, "R5");
        // R9: new start takes the select present at enable
        session(2'b11, 2'b11, 999, 10, 10, "R9");
        session(2'b01, 2'b01, 999, 13, 12, "R6");

        while (exp_q.size() > 0) @(posedge clk_i);
        repeat (3) @(posedge clk_i);
        report();
    end

endmodule